// File: doc/BRIEF.md
# 2D Rectangle Copy and Fill Engine

This block draws one rectangle at a time into a linear, byte-addressed video memory. Software loads a small register file with two surface descriptions (base address, line pitch, x/y corner), a rectangle size, a pixel format code, a raster-operation byte, a brush colour and two palette colours. A start strobe then launches the operation. Depending on the raster-operation byte, the engine either copies a rectangle from the source surface to the destination surface, or fills the destination rectangle with a solid colour taken from the brush or from one of the palette colours.

Before touching memory the engine checks the request: the pixel format must be known, the operation code must be one of four supported values, and both the surface base and the address of the row just past the rectangle must lie below the end of memory. A refused request raises the error flag and leaves memory untouched. An accepted request walks the rectangle row by row, left to right, one byte per memory transfer. When it finishes, the destination position register is moved on so that the next rectangle can be drawn next to or below the last one without software rewriting it. The memory port carries one byte per transfer and read data returns one cycle after the read request.

A format bit selects a second addressing mode in which pitches are given in pixels and a display offset is added to both surface bases.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, busy, done, err, mem_re and mem_we are low and every register reads back as zero.
- R2: The low four bits of the format register select the bytes per pixel: code 2 gives 1, codes 3 and 4 give 2, code 5 gives 3, code 6 gives 4.
- R3: Any other format code refuses the operation: err goes high, done pulses, and no memory read or write takes place.
- R4: The operation code is bits 23:16 of the mix register: 0xCC is copy, 0xF0 is brush fill, 0x00 is black fill, 0xFF is white fill; any other value is refused like R3. The other mix bits have no effect.
- R5: A copy moves width times bytes-per-pixel bytes per row for height rows, top row first and left to right, reading each source byte one cycle before writing it to the same offset in the destination; pixel (x, y) starts at base + y*pitch + x*bytes-per-pixel.
- R6: A brush fill writes the brush register with its four bytes reversed; byte k of every pixel (k counted from the lowest address) is bits 8k+7:8k of that swapped colour.
- R7: A black fill uses {black palette bits 23:0, 0xFF} and a white fill uses {white palette bits 23:0, 0xFF} as the colour, laid out as in R6.
- R8: The destination (and, for a copy, the source) is refused like R3 when its base is at or above the memory size, or when base + (y + height)*pitch + x*bytes-per-pixel is at or above the memory size.
- R9: After an accepted copy the destination x grows by width and the destination y by height; after an accepted fill only the destination y grows by height.
- R10: When format bit 8 is set, both pitches are multiplied by the bytes per pixel and the display offset register, masked to bits 26:0, is added to both bases.
- R11: A start strobe while busy is high is ignored: no second operation runs and done pulses only once.
- R12: done is high for exactly one cycle, the cycle after the last write (or after the refusal), and busy is low from that cycle on; err stays set until the next accepted start.
- R13: A width or height of zero completes with done, no memory access and no error, and the position update of R9 still applies.
- R14: Registers sit at word addresses 0 source base, 1 destination base, 2 source pitch, 3 destination pitch, 4 source position, 5 destination position, 6 size, 7 format, 8 mix, 9 brush, 10 black palette, 11 white palette, 12 display offset; positions pack y in bits 31:16 and x in bits 15:0, size packs height in 31:16 and width in 15:0, pitches use bits 15:0, and reg_rdata returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| start | input | 1 | Launch one operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Last operation was refused |
| mem_re | output | 1 | Memory byte read request |
| mem_we | output | 1 | Memory byte write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |

## Verification
On every cycle the assertions check the memory port discipline: reads and writes never overlap, every read is followed by a write, no transfer leaves the memory or happens while idle or while the error flag is set, and done is a single pulse that coincides with busy falling. What only the bench scenarios can show is the content of the traffic: byte order of the fill colours, the copied data and its row-major address sequence, the accept/refuse decision at the memory boundary, the pixel-pitch mode with its masked offset, and the position register after copy, fill and empty rectangles. The bench keeps its own memory and predicts every write address and byte before the operation starts.

// File: rtl/rbe_pkg.sv
package rbe_pkg;

  localparam int RA_W      = 4;
  localparam int NUM_REGS  = 13;
  localparam int REG_SLOTS = 1 << RA_W;

  localparam logic [RA_W-1:0] RA_SRC_BASE  = 4'd0;
  localparam logic [RA_W-1:0] RA_DST_BASE  = 4'd1;
  localparam logic [RA_W-1:0] RA_SRC_PITCH = 4'd2;
  localparam logic [RA_W-1:0] RA_DST_PITCH = 4'd3;
  localparam logic [RA_W-1:0] RA_SRC_XY    = 4'd4;
  localparam logic [RA_W-1:0] RA_DST_XY    = 4'd5;
  localparam logic [RA_W-1:0] RA_SIZE      = 4'd6;
  localparam logic [RA_W-1:0] RA_FORMAT    = 4'd7;
  localparam logic [RA_W-1:0] RA_MIX       = 4'd8;
  localparam logic [RA_W-1:0] RA_BRUSH     = 4'd9;
  localparam logic [RA_W-1:0] RA_PAL_BLK   = 4'd10;
  localparam logic [RA_W-1:0] RA_PAL_WHT   = 4'd11;
  localparam logic [RA_W-1:0] RA_DISP_OFS  = 4'd12;

  localparam logic [7:0] ROP_COPY  = 8'hCC;
  localparam logic [7:0] ROP_BRUSH = 8'hF0;
  localparam logic [7:0] ROP_BLACK = 8'h00;
  localparam logic [7:0] ROP_WHITE = 8'hFF;

  typedef enum logic [1:0] {OP_COPY, OP_FILL, OP_NONE} op_e;

  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_FILL} walk_st_e;

  typedef struct packed {
    logic [31:0] src_base;
    logic [31:0] dst_base;
    logic [15:0] src_pitch;
    logic [15:0] dst_pitch;
    logic [15:0] src_x;
    logic [15:0] src_y;
    logic [15:0] dst_x;
    logic [15:0] dst_y;
    logic [15:0] width;
    logic [15:0] height;
    logic [3:0]  fmt_code;
    logic        pix_pitch;
    logic [7:0]  rop;
    logic [31:0] brush;
    logic [23:0] pal_black;
    logic [23:0] pal_white;
    logic [26:0] disp_ofs;
  } cfg_t;

  function automatic logic [2:0] bytes_per_pixel(input logic [3:0] code);
    case (code)
      4'd2:       return 3'd1;
      4'd3, 4'd4: return 3'd2;
      4'd5:       return 3'd3;
      4'd6:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rbe_regs.sv
module rbe_regs
  import rbe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            upd_x,
  input  logic            upd_y,
  output cfg_t            cfg
);

  logic [31:0] regs_q [REG_SLOTS];

  for (genvar i = 0; i < REG_SLOTS; i++) begin : g_slot
    if (i < NUM_REGS) begin : g_reg
      logic [31:0] q, d;
      logic        en;
      if (i == int'(RA_DST_XY)) begin : g_pos
        always_comb begin
          en = 1'b1;
          if (reg_we && reg_addr == RA_W'(i)) begin
            d = reg_wdata;
          end else begin
            d[31:16] = q[31:16] + (upd_y ? regs_q[RA_SIZE][31:16] : 16'd0);
            d[15:0]  = q[15:0]  + (upd_x ? regs_q[RA_SIZE][15:0]  : 16'd0);
          end
        end
      end else begin : g_plain
        always_comb begin
          en = reg_we && (reg_addr == RA_W'(i));
          d  = reg_wdata;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end
      assign regs_q[i] = q;
    end else begin : g_hole
      assign regs_q[i] = '0;
    end
  end

  assign reg_rdata = regs_q[reg_addr];

  always_comb begin
    cfg.src_base  = regs_q[RA_SRC_BASE];
    cfg.dst_base  = regs_q[RA_DST_BASE];
    cfg.src_pitch = regs_q[RA_SRC_PITCH][15:0];
    cfg.dst_pitch = regs_q[RA_DST_PITCH][15:0];
    cfg.src_x     = regs_q[RA_SRC_XY][15:0];
    cfg.src_y     = regs_q[RA_SRC_XY][31:16];
    cfg.dst_x     = regs_q[RA_DST_XY][15:0];
    cfg.dst_y     = regs_q[RA_DST_XY][31:16];
    cfg.width     = regs_q[RA_SIZE][15:0];
    cfg.height    = regs_q[RA_SIZE][31:16];
    cfg.fmt_code  = regs_q[RA_FORMAT][3:0];
    cfg.pix_pitch = regs_q[RA_FORMAT][8];
    cfg.rop       = regs_q[RA_MIX][23:16];
    cfg.brush     = regs_q[RA_BRUSH];
    cfg.pal_black = regs_q[RA_PAL_BLK][23:0];
    cfg.pal_white = regs_q[RA_PAL_WHT][23:0];
    cfg.disp_ofs  = regs_q[RA_DISP_OFS][26:0];
  end

endmodule

// File: rtl/rbe_setup.sv
module rbe_setup
  import rbe_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter int ADDR_W    = 32
) (
  input  cfg_t              cfg,
  output op_e               op,
  output logic              refuse,
  output logic              empty,
  output logic [2:0]        bpb,
  output logic [18:0]       row_bytes,
  output logic [ADDR_W-1:0] src_start,
  output logic [ADDR_W-1:0] dst_start,
  output logic [ADDR_W-1:0] src_step,
  output logic [ADDR_W-1:0] dst_step,
  output logic [31:0]       color
);

  localparam int MW = 48;
  localparam logic [MW-1:0] MEM_END = MW'(MEM_BYTES);

  logic [MW-1:0] bpb_w, ofs, s_base, d_base, s_pitch, d_pitch, s_lim, d_lim;
  logic          s_bad, d_bad;

  always_comb begin
    bpb     = bytes_per_pixel(cfg.fmt_code);
    bpb_w   = MW'(bpb);
    ofs     = cfg.pix_pitch ? MW'(cfg.disp_ofs) : '0;
    s_pitch = cfg.pix_pitch ? MW'(cfg.src_pitch) * bpb_w : MW'(cfg.src_pitch);
    d_pitch = cfg.pix_pitch ? MW'(cfg.dst_pitch) * bpb_w : MW'(cfg.dst_pitch);
    s_base  = MW'(cfg.src_base) + ofs;
    d_base  = MW'(cfg.dst_base) + ofs;
    s_lim   = s_base + (MW'(cfg.src_y) + MW'(cfg.height)) * s_pitch + MW'(cfg.src_x) * bpb_w;
    d_lim   = d_base + (MW'(cfg.dst_y) + MW'(cfg.height)) * d_pitch + MW'(cfg.dst_x) * bpb_w;
    s_bad   = (s_base >= MEM_END) || (s_lim >= MEM_END);
    d_bad   = (d_base >= MEM_END) || (d_lim >= MEM_END);

    src_start = ADDR_W'(s_base + MW'(cfg.src_y) * s_pitch + MW'(cfg.src_x) * bpb_w);
    dst_start = ADDR_W'(d_base + MW'(cfg.dst_y) * d_pitch + MW'(cfg.dst_x) * bpb_w);
    src_step  = ADDR_W'(s_pitch);
    dst_step  = ADDR_W'(d_pitch);
    row_bytes = 19'(cfg.width) * 19'(bpb);
    empty     = (cfg.width == 16'd0) || (cfg.height == 16'd0);

    case (cfg.rop)
      ROP_COPY:                       op = OP_COPY;
      ROP_BRUSH, ROP_BLACK, ROP_WHITE: op = OP_FILL;
      default:                        op = OP_NONE;
    endcase

    case (cfg.rop)
      ROP_BRUSH: color = {cfg.brush[7:0], cfg.brush[15:8], cfg.brush[23:16], cfg.brush[31:24]};
      ROP_BLACK: color = {cfg.pal_black, 8'hFF};
      default:   color = {cfg.pal_white, 8'hFF};
    endcase

    refuse = (bpb == 3'd0) || (op == OP_NONE) || d_bad || ((op == OP_COPY) && s_bad);
  end

endmodule

// File: rtl/rbe_walker.sv
module rbe_walker
  import rbe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               op,
  input  logic              refuse,
  input  logic              empty,
  input  logic [2:0]        bpb,
  input  logic [18:0]       row_bytes,
  input  logic [15:0]       height,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [ADDR_W-1:0] src_step,
  input  logic [ADDR_W-1:0] dst_step,
  input  logic [31:0]       color,
  input  logic [7:0]        mem_rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              upd_x,
  output logic              upd_y
);

  walk_st_e          state_q, state_n;
  logic [ADDR_W-1:0] src_row_q, src_row_n, dst_row_q, dst_row_n;
  logic [18:0]       col_q, col_n;
  logic [1:0]        lane_q, lane_n;
  logic [15:0]       rows_q, rows_n;
  logic              done_q, done_n, err_q, err_n;
  logic              adv, ptr_en, is_copy;

  always_comb begin
    state_n   = state_q;
    src_row_n = src_row_q;
    dst_row_n = dst_row_q;
    col_n     = col_q;
    lane_n    = lane_q;
    rows_n    = rows_q;
    done_n    = 1'b0;
    err_n     = err_q;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    upd_x     = 1'b0;
    upd_y     = 1'b0;
    adv       = 1'b0;
    is_copy   = (state_q == ST_WRITE);
    case (state_q)
      ST_IDLE: if (start) begin
        state_n = ST_CHECK;
        err_n   = 1'b0;
      end
      ST_CHECK: begin
        if (refuse) begin
          state_n = ST_IDLE;
          err_n   = 1'b1;
          done_n  = 1'b1;
        end else if (empty) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          upd_x   = (op == OP_COPY);
          upd_y   = 1'b1;
        end else begin
          src_row_n = src_start;
          dst_row_n = dst_start;
          col_n     = '0;
          lane_n    = '0;
          rows_n    = height;
          state_n   = (op == OP_COPY) ? ST_READ : ST_FILL;
        end
      end
      ST_READ: begin
        mem_re   = 1'b1;
        mem_addr = src_row_q + ADDR_W'(col_q);
        state_n  = ST_WRITE;
      end
      ST_WRITE: begin
        mem_we    = 1'b1;
        mem_addr  = dst_row_q + ADDR_W'(col_q);
        mem_wdata = mem_rdata;
        adv       = 1'b1;
      end
      ST_FILL: begin
        mem_we    = 1'b1;
        mem_addr  = dst_row_q + ADDR_W'(col_q);
        mem_wdata = color[{lane_q, 3'b000} +: 8];
        adv       = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase

    if (adv) begin
      if (col_q == row_bytes - 19'd1) begin
        if (rows_q == 16'd1) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          upd_x   = is_copy;
          upd_y   = 1'b1;
        end else begin
          rows_n    = rows_q - 16'd1;
          col_n     = '0;
          lane_n    = '0;
          src_row_n = src_row_q + src_step;
          dst_row_n = dst_row_q + dst_step;
          state_n   = is_copy ? ST_READ : ST_FILL;
        end
      end else begin
        col_n   = col_q + 19'd1;
        lane_n  = ({1'b0, lane_q} == bpb - 3'd1) ? 2'd0 : lane_q + 2'd1;
        state_n = is_copy ? ST_READ : ST_FILL;
      end
    end
    ptr_en = (state_q == ST_CHECK) || adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_row_q <= '0;
      dst_row_q <= '0;
      col_q     <= '0;
      lane_q    <= '0;
      rows_q    <= '0;
    end else if (ptr_en) begin
      src_row_q <= src_row_n;
      dst_row_q <= dst_row_n;
      col_q     <= col_n;
      lane_q    <= lane_n;
      rows_q    <= rows_n;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import rbe_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  cfg_t              cfg;
  op_e               op;
  logic              refuse, empty, upd_x, upd_y;
  logic [2:0]        bpb;
  logic [18:0]       row_bytes;
  logic [ADDR_W-1:0] src_start, dst_start, src_step, dst_step;
  logic [31:0]       color;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rbe_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .upd_x     (upd_x),
    .upd_y     (upd_y),
    .cfg       (cfg)
  );

  rbe_setup #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_setup (
    .cfg       (cfg),
    .op        (op),
    .refuse    (refuse),
    .empty     (empty),
    .bpb       (bpb),
    .row_bytes (row_bytes),
    .src_start (src_start),
    .dst_start (dst_start),
    .src_step  (src_step),
    .dst_step  (dst_step),
    .color     (color)
  );

  rbe_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .op        (op),
    .refuse    (refuse),
    .empty     (empty),
    .bpb       (bpb),
    .row_bytes (row_bytes),
    .height    (cfg.height),
    .src_start (src_start),
    .dst_start (dst_start),
    .src_step  (src_step),
    .dst_step  (dst_step),
    .color     (color),
    .mem_rdata (mem_rdata),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .upd_x     (upd_x),
    .upd_y     (upd_y)
  );

endmodule

// File: rtl/rect_blit_engine_chk.sv
module rect_blit_engine_chk #(
  parameter int MEM_BYTES = 4096,
  parameter int ADDR_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_re,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  assert_port_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);

  assert_addr_in_memory_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> (mem_addr < ADDR_W'(MEM_BYTES)));

  assert_refused_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(mem_re || mem_we));

  assert_access_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> busy);

  assert_start_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind rect_blit_engine rect_blit_engine_chk #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/rect_blit_engine_tb.sv
module rect_blit_engine_tb;

  localparam int MEM = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        start = 1'b0;
  logic        busy, done, err, mem_re, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'd0;

  logic [7:0]  mem [MEM];
  int          total = 0, fails = 0, cyc = 0;
  int          q_addr[$];
  int          q_data[$];
  bit          allow_rd = 1'b0;

  int sbase, dbase, sp, dp, sx, sy, dx, dy, w, h, fmt, mix, brush, palb, palw, dofs;

  always #10 clk = ~clk;

  rect_blit_engine #(.MEM_BYTES(MEM), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start), .busy(busy),
    .done(done), .err(err), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial for (int i = 0; i < MEM; i++) mem[i] = 8'(i * 7 + 3);

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
  end

  // per-clock comparison of the port against the predicted write stream
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q_addr.size() == 0) chk(0, "R3/R5 unexpected write", mem_addr, 0);
      else begin
        int ea, ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        chk(mem_addr == 32'(ea) && mem_wdata == 8'(ed), "R5/R6/R7 write addr/data",
            {mem_addr, mem_wdata}, {32'(ea), 8'(ed)});
      end
    end
    if (rst_n && mem_re && !allow_rd) chk(0, "R3 unexpected read", mem_addr, 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wreg(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic program_all();
    wreg(4'd0, sbase); wreg(4'd1, dbase); wreg(4'd2, sp); wreg(4'd3, dp);
    wreg(4'd4, {sy[15:0], sx[15:0]}); wreg(4'd5, {dy[15:0], dx[15:0]});
    wreg(4'd6, {h[15:0], w[15:0]}); wreg(4'd7, fmt); wreg(4'd8, mix);
    wreg(4'd9, brush); wreg(4'd10, palb); wreg(4'd11, palw); wreg(4'd12, dofs);
  endtask

  function automatic int bpp_of(input int code);
    case (code & 15)
      2: return 1; 3, 4: return 2; 5: return 3; 6: return 4; default: return 0;
    endcase
  endfunction

  task automatic run_op(input bit exp_err, input string tag, input bit extra_start);
    int b, spb, dpb, ofs, rop, col, ndone;
    bit is_copy;
    logic [31:0] rd;
    b   = bpp_of(fmt);
    rop = (mix >> 16) & 255;
    is_copy = (rop == 8'hCC);
    ofs = fmt[8] ? (dofs & 32'h07FF_FFFF) : 0;
    spb = fmt[8] ? sp * b : sp;
    dpb = fmt[8] ? dp * b : dp;
    col = (rop == 8'hF0) ? {brush[7:0], brush[15:8], brush[23:16], brush[31:24]}
        : (rop == 8'h00) ? {palb[23:0], 8'hFF} : {palw[23:0], 8'hFF};
    program_all();
    if (!exp_err)
      for (int j = 0; j < h; j++)
        for (int c = 0; c < w * b; c++) begin
          q_addr.push_back(dbase + ofs + (dy + j) * dpb + dx * b + c);
          if (is_copy) q_data.push_back(int'(mem[sbase + ofs + (sy + j) * spb + sx * b + c]));
          else         q_data.push_back((col >> (8 * (c % b))) & 255);
        end
    allow_rd = is_copy && !exp_err;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra_start) begin
      repeat (2) @(negedge clk);
      chk(busy == 1'b1, "R11 busy when second start", busy, 1);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    ndone = 0;
    for (int k = 0; k < 5000 && ndone == 0; k++) begin
      if (done) ndone++;
      else @(negedge clk);
    end
    chk(ndone == 1, {tag, " R12 done seen"}, ndone, 1);
    chk(err == exp_err, {tag, " R3/R4/R8 err flag"}, err, exp_err);
    chk(busy == 1'b0, {tag, " R12 busy low with done"}, busy, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R12 done one cycle"}, done, 0);
    chk(q_addr.size() == 0, {tag, " R5 all writes issued"}, q_addr.size(), 0);
    if (extra_start) begin
      repeat (6) begin
        @(negedge clk);
        if (done || busy) chk(0, "R11 second op started", {busy, done}, 0);
      end
      chk(busy == 1'b0, "R11 idle after ignored start", busy, 0);
    end
    if (exp_err) begin
      repeat (3) @(negedge clk);
      chk(err == 1'b1, {tag, " R12 err held"}, err, 1);
    end else begin
      dy = dy + h;
      if (is_copy) dx = dx + w;
    end
    rreg(4'd5, rd);
    chk(rd == {dy[15:0], dx[15:0]}, {tag, " R9 position update"}, rd, {dy[15:0], dx[15:0]});
    allow_rd = 1'b0;
  endtask

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && !mem_re && !mem_we, "R1 idle outputs", {busy, done, err}, 0);
    rreg(4'd5, rd); chk(rd == 0, "R1 position reset", rd, 0);
    rreg(4'd9, rd); chk(rd == 0, "R1 brush reset", rd, 0);

    sbase = 0; sp = 0; sx = 0; sy = 0; dofs = 32'hF800_0200;
    palb = 32'hEE12_3456; palw = 32'h77AB_CDEF; brush = 32'h1122_3344;

    // R6 brush fill, 32 bpp (code 6)
    dbase = 32'h100; dp = 64; dx = 2; dy = 1; w = 3; h = 2; fmt = 6; mix = 32'h00F0_0000;
    run_op(0, "R6 brush fill 32bpp", 0);
    rreg(4'd9, rd); chk(rd == 32'h1122_3344, "R14 brush readback", rd, 32'h1122_3344);
    // R7 black fill 16 bpp (code 3), white fill 24 bpp (code 5)
    dx = 1; dy = 0; w = 2; h = 2; fmt = 3; mix = 32'h0000_0000;
    run_op(0, "R7 black fill 16bpp", 0);
    w = 2; h = 1; fmt = 5; mix = 32'h00FF_0000;
    run_op(0, "R7 white fill 24bpp", 0);
    // R5 copy 16 bpp (code 4), other mix bits set (R4)
    sbase = 32'h800; sp = 32; sx = 1; sy = 1; dbase = 32'h600; dp = 32; dx = 0; dy = 0;
    w = 3; h = 2; fmt = 4; mix = 32'hFFCC_FFFF;
    run_op(0, "R5 R4 copy 16bpp", 0);
    // R2 copy 8 bpp (code 2)
    w = 4; h = 3; fmt = 2;
    run_op(0, "R2 copy 8bpp", 0);
    // R3 unsupported formats
    fmt = 7; run_op(1, "R3 format 7", 0);
    fmt = 0; run_op(1, "R3 format 0", 0);
    // R4 unknown operation
    fmt = 2; mix = 32'h0055_0000; run_op(1, "R4 rop 0x55", 0);
    // R8 bounds
    mix = 32'h00F0_0000; dbase = MEM; dx = 0; dy = 0; w = 4; h = 1;
    run_op(1, "R8 dst base at end", 0);
    dbase = 0; dp = 256; dy = 14; h = 2;
    run_op(1, "R8 row limit at end", 0);
    dy = 13; h = 2; dx = 0;
    run_op(0, "R8 row limit just inside", 0);
    mix = 32'h00CC_0000; sbase = MEM; dy = 0; h = 1;
    run_op(1, "R8 src base at end", 0);
    // R10 pixel-pitch mode, 32 bpp, masked display offset
    sbase = 32'h10; sp = 4; sx = 0; sy = 0; dbase = 32'h400; dp = 8; dx = 1; dy = 1;
    w = 2; h = 2; fmt = 32'h106;
    run_op(0, "R10 pixel pitch copy", 0);
    // R11 start while busy
    fmt = 2; mix = 32'h00F0_0000; dbase = 32'h300; dp = 16; dx = 0; dy = 0; w = 8; h = 1;
    run_op(0, "R11 fill with extra start", 1);
    // R13 empty rectangles
    w = 0; h = 3; run_op(0, "R13 zero width fill", 0);
    mix = 32'h00CC_0000; sbase = 0; w = 5; h = 0; run_op(0, "R13 zero height copy", 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule